// File: doc/BRIEF.md
# Scan-Code Queue Presenter

This block sits between a keyboard receiver and a host CPU that polls a single parallel byte register. Received scan codes enter through a valid/ready stream and wait in a small circular queue. Whenever the host-visible output register holds nothing unread and the queue has data, the block removes the oldest code. It clocks that code bit by bit into a staging register and then copies the staging register to the output register in one step.

The host reads the output register by pulling an active-low chip-enable. Each falling edge of that line is synchronised and detected once. The detected edge empties the output register to zero and frees it for the next code. A zero read therefore always means "nothing new", and a code can never be read twice by mistake.

Back-pressure rules of the input stream: `in_ready` is high whenever the queue has a free entry, and a beat is taken on any clock edge where `in_valid` and `in_ready` are both high. The receiver side cannot stall, so a beat offered while `in_ready` is low is not held for retry. It is discarded, and `overflow` pulses for one cycle.

Top module: `scan_fifo_presenter`

## Requirements
- R1: After reset, `out_q` is 0x00, `pending` is low, `in_ready` is high and `overflow` is low.
- R2: Codes appear on `out_q` in the order they were accepted, including after the queue pointers have wrapped past the last entry many times.
- R3: A code is removed from the queue only when the queue is non-empty and `pending` is low. While `pending` stays high, `out_q` does not change.
- R4: Every accepted 8-bit value, 0x00 through 0xFF, reaches `out_q` unaltered. `out_q` changes from zero straight to the full value, with no partially shifted value ever visible.
- R5: A falling edge on `host_ce_n` clears `out_q` to 0x00 and drops `pending` within three clock cycles. Holding `host_ce_n` low, or raising it again, clears nothing further, so a code latched while the line stays low remains on `out_q`.
- R6: Whenever `pending` is low, `out_q` reads 0x00. After a clear with an empty queue, it stays 0x00 until a new code is accepted and transferred.
- R7: `in_ready` is low exactly when all DEPTH entries hold codes. A beat offered with `in_valid` high while `in_ready` is low is dropped, and it never reaches `out_q`. `overflow` is high in the cycle after such a beat, and only then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Scan-code beat offered |
| in_ready | output | 1 | Queue has a free entry |
| in_data | input | 8 | Scan-code byte |
| host_ce_n | input | 1 | Host read strobe, active low, asynchronous |
| out_q | output | 8 | Host-visible code register, zero when nothing is unread |
| pending | output | 1 | Output register holds a code not yet read |
| overflow | output | 1 | One-cycle pulse after a beat was dropped on a full queue |

## Verification
A sweep pushes every byte value one at a time and reads each one back. It separates bit-order or shift-count faults, which corrupt some values, from a correct serial path, and it wraps the queue pointers dozens of times. A burst fills the queue behind an unread code and offers one more beat. This shows whether ordering, the full boundary, drop-on-full and the hold-off while the output is pending are all handled. A read that keeps chip-enable low across the next transfer tells single-edge clearing apart from level clearing.

// File: rtl/scanq_pkg.sv
package scanq_pkg;
  localparam int unsigned CODE_W = 8;

  typedef enum logic [1:0] {
    XF_IDLE  = 2'd0,
    XF_SHIFT = 2'd1,
    XF_LATCH = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/scanq_ring.sv
module scanq_ring #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned OCW  = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [W-1:0]   wr_data,
  input  logic           rd_en,
  output logic [W-1:0]   rd_data,
  output logic           empty,
  output logic           full,
  output logic [OCW-1:0] occ
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (wr_en) wr_ptr <= step(wr_ptr);
      if (rd_en) rd_ptr <= step(rd_ptr);
      case ({wr_en, rd_en})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  assign rd_data = mem[rd_ptr];
  assign empty   = (occ == '0);
  assign full    = (occ == OCW'(DEPTH));
endmodule

// File: rtl/scanq_ce_edge.sv
module scanq_ce_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n_async,
  output logic rd_pulse
);
  // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-1:0], ce_n_async};
  end

  assign rd_pulse = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/scanq_presenter.sv
module scanq_presenter
  import scanq_pkg::*;
#(
  parameter int unsigned W = 8,
  localparam int unsigned BCW = (W > 1) ? $clog2(W) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         avail,
  input  logic [W-1:0] pop_data,
  input  logic         rd_clr,
  output logic         pop,
  output logic [W-1:0] out_q,
  output logic         pending
);
  xfer_state_e    state;
  logic [W-1:0]   src;
  logic [W-1:0]   stage;
  logic [BCW-1:0] bitcnt;

  assign pop = (state == XF_IDLE) && avail && !pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= XF_IDLE;
      src     <= '0;
      stage   <= '0;
      bitcnt  <= '0;
      out_q   <= '0;
      pending <= 1'b0;
    end else begin
      case (state)
        XF_IDLE: begin
          if (pop) begin
            src    <= pop_data;
            bitcnt <= '0;
            state  <= XF_SHIFT;
          end
        end
        XF_SHIFT: begin
          // one shift-clock pulse: MSB of the source enters the stage
          stage  <= {stage[W-2:0], src[W-1]};
          src    <= {src[W-2:0], 1'b0};
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == BCW'(W - 1)) state <= XF_LATCH;
        end
        XF_LATCH: begin
          out_q   <= stage;
          pending <= 1'b1;
          state   <= XF_IDLE;
        end
        default: state <= XF_IDLE;
      endcase

      // host read: a latch in the same cycle takes priority
      if (rd_clr && state != XF_LATCH) begin
        out_q   <= '0;
        pending <= 1'b0;
        if (state == XF_IDLE) stage <= '0;
      end
    end
  end
endmodule

// File: rtl/scan_fifo_presenter.sv
module scan_fifo_presenter
  import scanq_pkg::*;
#(
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned CE_STAGES = 2,
  localparam int unsigned OCW      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CODE_W-1:0] in_data,
  input  logic              host_ce_n,
  output logic [CODE_W-1:0] out_q,
  output logic              pending,
  output logic              overflow
);
  logic              q_empty, q_full, q_pop, rd_pulse;
  logic [CODE_W-1:0] q_head;
  logic [OCW-1:0]    occ;
  logic              q_push;

  assign in_ready = !q_full;
  assign q_push   = in_valid && !q_full;

  scanq_ring #(.W(CODE_W), .DEPTH(DEPTH)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (q_push),
    .wr_data (in_data),
    .rd_en   (q_pop),
    .rd_data (q_head),
    .empty   (q_empty),
    .full    (q_full),
    .occ     (occ)
  );

  scanq_ce_edge #(.STAGES(CE_STAGES)) u_ce (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n_async (host_ce_n),
    .rd_pulse   (rd_pulse)
  );

  scanq_presenter #(.W(CODE_W)) u_pres (
    .clk      (clk),
    .rst_n    (rst_n),
    .avail    (!q_empty),
    .pop_data (q_head),
    .rd_clr   (rd_pulse),
    .pop      (q_pop),
    .out_q    (out_q),
    .pending  (pending)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) overflow <= 1'b0;
    else        overflow <= in_valid && q_full;
  end
endmodule

// File: rtl/scan_presenter_chk.sv
module scan_presenter_chk #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned OCW  = $clog2(DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic           overflow,
  input logic [7:0]     out_q,
  input logic           pending,
  input logic [OCW-1:0] occ
);
  assert_zero_when_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |-> out_q == 8'h00);

  assert_hold_while_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pending && $past(pending) |-> $stable(out_q));

  assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_q) |-> (out_q == 8'h00) || ($past(out_q) == 8'h00));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $past(in_valid && !in_ready));

  assert_occ_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCW'(DEPTH));

  assert_ready_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == OCW'(DEPTH)) |-> !in_ready);
endmodule

bind scan_fifo_presenter scan_presenter_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .overflow (overflow),
  .out_q    (out_q),
  .pending  (pending),
  .occ      (occ)
);

// File: tb/tb_scan_fifo_presenter.sv
module tb_scan_fifo_presenter;
  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       host_ce_n = 1'b1;
  logic       in_ready, pending, overflow;
  logic [7:0] out_q;

  int compared = 0;
  int mismatched = 0;

  always #2.5 clk = ~clk;

  scan_fifo_presenter #(.DEPTH(DEPTH)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .host_ce_n (host_ce_n),
    .out_q     (out_q),
    .pending   (pending),
    .overflow  (overflow)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  task automatic push(input logic [7:0] v);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = v;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // read strobe: low for four cycles, then released
  task automatic host_read();
    @(negedge clk);
    host_ce_n = 1'b0;
    repeat (4) @(negedge clk);
    host_ce_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // waits for a code; out_q must read zero while nothing is pending (R6, R4)
  task automatic wait_code(input logic [7:0] exp, input string req);
    bit partial = 0;
    int n = 0;
    while (!pending && n < 40) begin
      if (out_q != 8'h00) partial = 1;
      @(negedge clk);
      n++;
    end
    chk(!partial, "R4 no partial value before latch", 0, 0);
    chk(pending && out_q == exp, req, {pending, out_q}, {1'b1, exp});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_q == 8'h00 && !pending && in_ready && !overflow, "R1 reset state",
        {out_q, pending, in_ready, overflow}, {8'h00, 3'b010});
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_q == 8'h00 && !pending, "R1 idle after reset", {out_q, pending}, 0);

    // R4 / R2 / R5: every byte value, pointers wrap 32 times
    for (int v = 0; v < 256; v++) begin
      push(v[7:0]);
      wait_code(v[7:0], "R4 value delivered unaltered (R2 wrap)");
      host_read();
      chk(out_q == 8'h00 && !pending, "R5 read clears output",
          {pending, out_q}, 0);
    end

    // R3 / R7 / R2: fill behind an unread code
    push(8'hC3);
    wait_code(8'hC3, "R2 first code of burst");
    for (int i = 0; i < DEPTH; i++) begin
      chk(in_ready, "R7 ready while not full", in_ready, 1);
      push(8'h10 + i[7:0]);
    end
    chk(!in_ready, "R7 ready low when full", in_ready, 0);
    chk(!overflow, "R7 no overflow on accepted beats", overflow, 0);
    // offer a beat to the full queue; overflow seen at the next negedge
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 8'hEE;
    @(negedge clk);
    in_valid = 1'b0;
    chk(overflow, "R7 overflow pulse on drop", overflow, 1);
    @(negedge clk);
    chk(!overflow, "R7 overflow lasts one cycle", overflow, 0);
    repeat (20) @(negedge clk);
    chk(out_q == 8'hC3 && pending, "R3 output held while pending", out_q, 8'hC3);

    // drain in order; R5 hold-low on the first read
    @(negedge clk);
    host_ce_n = 1'b0;
    repeat (40) @(negedge clk);
    chk(pending && out_q == 8'h10, "R5 level low clears only once", out_q, 8'h10);
    host_ce_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(pending && out_q == 8'h10, "R5 rising edge does not clear", out_q, 8'h10);
    for (int i = 1; i < DEPTH; i++) begin
      host_read();
      wait_code(8'h10 + i[7:0], "R2 order after fill");
    end
    host_read();
    repeat (40) @(negedge clk);
    chk(out_q == 8'h00 && !pending, "R7 dropped beat never appears / R6 stays zero",
        {pending, out_q}, 0);
    chk(in_ready, "R7 ready after drain", in_ready, 1);

    // R6: clear with queue non-empty still reads zero until next latch
    push(8'h5A);
    wait_code(8'h5A, "R2 single code");
    push(8'hA5);
    repeat (3) @(negedge clk);
    chk(out_q == 8'h5A, "R3 no transfer while pending", out_q, 8'h5A);
    @(negedge clk);
    host_ce_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_q == 8'h00 && !pending, "R6 zero right after read", {pending, out_q}, 0);
    host_ce_n = 1'b1;
    wait_code(8'hA5, "R3 next code after clear");
    host_read();

    summary();
    $finish;
  end
endmodule